// File: doc/BRIEF.md
# Prefix Relocator with Page Reference and Change Tracking

This block sits between a translation stage, which produces real addresses, and physical memory. A programmable prefix base names an 8 KiB area of storage. Real addresses in the lowest 8 KiB are redirected into that area, and real addresses inside that area are redirected down to the lowest 8 KiB. The two windows swap places, and every other address passes through unchanged. The length of a relocated access is cut at the edge of its 8 KiB window, so a single access never straddles the swap boundary. The caller issues the remainder as a new access.

Each request is treated as a completed access. The block records it in a small key array that holds one entry per 4 KiB page of configured memory. A read permission sets the page's reference bit and a write permission sets its change bit. The page is picked from the absolute address after relocation. A clear input wipes all bits, and a read port returns one page's bits one cycle after the request. Protection checking and the memory itself lie outside the block.

Top module: `prx_relocator`

## Requirements
- R1: After reset the prefix base is zero, rel_valid is low and every page's key bits read back as 2'b00, so a low address leaves the block unchanged.
- R2: A write on pfx_we loads the prefix base from pfx_wdata with bits [12:0] forced to zero. Requests accepted from the next cycle onward use the new base.
- R3: A request with req_addr below 8192 yields rel_addr = req_addr + base and rel_len = min(req_len, 8192 - req_addr). rel_valid, rel_addr and rel_len appear one cycle after req_valid.
- R4: A request with req_addr at or above 8192 and inside [base, base+8192) yields rel_addr = req_addr - base and rel_len = min(req_len, 8192 - rel_addr).
- R5: Any other request leaves both address and length unchanged, including the first byte after the prefix window and address 8192 itself.
- R6: A request with req_rd sets bit 0 (reference) and one with req_wr sets bit 1 (change) of the key for page rel_addr/4096. Bits are sticky and only ever set.
- R7: Key bits change only when the absolute address is at most MEM_BYTES. An access above MEM_BYTES leaves every key unchanged.
- R8: key_clr clears the key bits of all pages. A request in the same cycle as key_clr leaves no bit set.
- R9: key_rd_en returns the bits of page key_rd_idx on key_rd_data with key_rd_valid one cycle later. A read in the same cycle as an update to that page returns the value before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_we | input | 1 | Prefix base write strobe |
| pfx_wdata | input | ADDR_W | New prefix base (low 13 bits ignored) |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Real start address |
| req_len | input | LEN_W | Requested length in bytes |
| req_rd | input | 1 | Access has read permission |
| req_wr | input | 1 | Access has write permission |
| rel_valid | output | 1 | Relocated access valid |
| rel_addr | output | ADDR_W | Absolute start address |
| rel_len | output | LEN_W | Clipped length |
| key_clr | input | 1 | Clear all reference and change bits |
| key_rd_en | input | 1 | Key read request |
| key_rd_idx | input | KEY_IDX_W | Page number to read |
| key_rd_valid | output | 1 | Key read data valid |
| key_rd_data | output | 2 | {change, reference} of the page read |

## Verification
The bench aims at the window edges. It uses the last byte of low storage, address 8192, and the first and last pages of the prefix area. A design that compared with the wrong inclusive bound would relocate address 8192 or the byte just past the prefix area, or would compute an off-by-one clipped length. It also writes a prefix value with low bits set, which a design that failed to mask them would shift off its alignment. For keys, the bench tests accesses exactly at and just above the memory limit, which a wrong comparison would wrongly mark. It also tests a clear colliding with an update, and a read colliding with an update to the same page. A design that got the priority or the read order wrong would leave a stray bit or return the new value early.

// File: rtl/prx_pkg.sv
package prx_pkg;
  // Size of each swapped window in bytes and its address bit split
  localparam int WIN_SHIFT = 13;
  localparam int WIN_BYTES = 1 << WIN_SHIFT;
  // Page granularity of the key array
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
  // Key bit positions
  localparam int KEY_REF = 0;
  localparam int KEY_CHG = 1;

  typedef enum logic [1:0] {
    ZONE_PASS = 2'd0,
    ZONE_LOW  = 2'd1,
    ZONE_WIN  = 2'd2
  } prx_zone_e;
endpackage

// File: rtl/prx_prefix_reg.sv
module prx_prefix_reg
  import prx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base
);
  localparam int HI_W = ADDR_W - WIN_SHIFT;

  logic [HI_W-1:0] base_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
    end else if (wr_en) begin
      base_hi <= wr_data[ADDR_W-1:WIN_SHIFT];
    end
  end

  // Window alignment: the low bits never hold state
  assign base = {base_hi, {WIN_SHIFT{1'b0}}};
endmodule

// File: rtl/prx_reloc.sv
module prx_reloc
  import prx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output prx_zone_e         zone_c,
  output logic [ADDR_W-1:0] abs_c,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [LEN_W-1:0]  rel_len
);
  localparam int HI_W = ADDR_W - WIN_SHIFT;

  // Bytes left in the window from an offset inside it
  function automatic logic [LEN_W-1:0] f_room(input logic [WIN_SHIFT-1:0] off);
    f_room = LEN_W'(WIN_BYTES) - LEN_W'(off);
  endfunction

  // Limit a length to the room left
  function automatic logic [LEN_W-1:0] f_clip(input logic [LEN_W-1:0] len,
                                              input logic [LEN_W-1:0] room);
    f_clip = (len > room) ? room : len;
  endfunction

  // Classify an address against the low area and the prefix area
  function automatic prx_zone_e f_zone(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
    if (a[ADDR_W-1:WIN_SHIFT] == '0)
      f_zone = ZONE_LOW;
    else if (a[ADDR_W-1:WIN_SHIFT] == b[ADDR_W-1:WIN_SHIFT])
      f_zone = ZONE_WIN;
    else
      f_zone = ZONE_PASS;
  endfunction

  logic [WIN_SHIFT-1:0] off_c;
  logic [LEN_W-1:0]     len_c;

  assign zone_c = f_zone(req_addr, base);
  assign off_c  = req_addr[WIN_SHIFT-1:0];

  always_comb begin
    unique case (zone_c)
      ZONE_LOW: begin
        abs_c = {base[ADDR_W-1:WIN_SHIFT], off_c};
        len_c = f_clip(req_len, f_room(off_c));
      end
      ZONE_WIN: begin
        abs_c = {{HI_W{1'b0}}, off_c};
        len_c = f_clip(req_len, f_room(off_c));
      end
      default: begin
        abs_c = req_addr;
        len_c = req_len;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid <= 1'b0;
      rel_addr  <= '0;
      rel_len   <= '0;
    end else begin
      rel_valid <= req_valid;
      if (req_valid) begin
        rel_addr <= abs_c;
        rel_len  <= len_c;
      end
    end
  end
endmodule

// File: rtl/prx_key_array.sv
module prx_key_array
  import prx_pkg::*;
#(
  parameter int DEPTH = 65,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [1:0]       upd_set,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [1:0]       rd_data
);
  logic [1:0] keys [DEPTH];
  logic [1:0] rd_c;

  for (genvar g = 0; g < DEPTH; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        keys[g] <= 2'b00;
      end else if (upd_en && (upd_idx == IDX_W'(g))) begin
        keys[g] <= keys[g] | upd_set;
      end
    end
  end

  always_comb begin
    rd_c = 2'b00;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_c = keys[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 2'b00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_c;
    end
  end
endmodule

// File: rtl/prx_relocator.sv
module prx_relocator
  import prx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MEM_BYTES = 262144,
  localparam int KEY_DEPTH = MEM_BYTES / PAGE_BYTES + 1,
  localparam int KEY_IDX_W = $clog2(KEY_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pfx_we,
  input  logic [ADDR_W-1:0]    pfx_wdata,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_rd,
  input  logic                 req_wr,
  output logic                 rel_valid,
  output logic [ADDR_W-1:0]    rel_addr,
  output logic [LEN_W-1:0]     rel_len,
  input  logic                 key_clr,
  input  logic                 key_rd_en,
  input  logic [KEY_IDX_W-1:0] key_rd_idx,
  output logic                 key_rd_valid,
  output logic [1:0]           key_rd_data
);
  localparam logic [ADDR_W-1:0] MEM_LIM = ADDR_W'(MEM_BYTES);

  // Named internal events for the checker
  logic [ADDR_W-1:0]    pfx_base;
  prx_zone_e            zone_c;
  logic [ADDR_W-1:0]    abs_c;
  logic                 in_mem;
  logic                 key_upd;
  logic [KEY_IDX_W-1:0] key_page;
  logic [1:0]           key_set;

  prx_prefix_reg #(.ADDR_W(ADDR_W)) u_pfx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pfx_we),
    .wr_data (pfx_wdata),
    .base    (pfx_base)
  );

  prx_reloc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_reloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (pfx_base),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .zone_c    (zone_c),
    .abs_c     (abs_c),
    .rel_valid (rel_valid),
    .rel_addr  (rel_addr),
    .rel_len   (rel_len)
  );

  assign in_mem   = (abs_c <= MEM_LIM);
  assign key_page = abs_c[PAGE_SHIFT +: KEY_IDX_W];
  assign key_set  = {req_wr, req_rd};
  assign key_upd  = req_valid && in_mem && (key_set != 2'b00);

  prx_key_array #(.DEPTH(KEY_DEPTH), .IDX_W(KEY_IDX_W)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (key_clr),
    .upd_en   (key_upd),
    .upd_idx  (key_page),
    .upd_set  (key_set),
    .rd_en    (key_rd_en),
    .rd_idx   (key_rd_idx),
    .rd_valid (key_rd_valid),
    .rd_data  (key_rd_data)
  );
endmodule

// File: rtl/prx_checker.sv
module prx_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pfx_we,
  input logic [ADDR_W-1:0] pfx_wdata,
  input logic [ADDR_W-1:0] pfx_base,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              rel_valid,
  input logic [ADDR_W-1:0] rel_addr,
  input logic [LEN_W-1:0]  rel_len,
  input logic              key_rd_en,
  input logic              key_rd_valid
);
  localparam int WS = 13;

  // R2
  prefix_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_we |=> pfx_base == {$past(pfx_wdata[ADDR_W-1:WS]), {WS{1'b0}}});

  // R3
  rel_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid == $past(req_valid));

  // R3
  low_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && ($past(req_addr) < ADDR_W'(8192)))
    |-> (rel_addr == $past(req_addr) + $past(pfx_base)) && (rel_len <= $past(req_len)));

  // R4
  win_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && ($past(req_addr) >= ADDR_W'(8192)) &&
     ($past(req_addr[ADDR_W-1:WS]) == $past(pfx_base[ADDR_W-1:WS])))
    |-> (rel_addr < ADDR_W'(8192)) && (32'(rel_addr[WS-1:0]) + 32'(rel_len) <= 32'd8192));

  // R5
  pass_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && ($past(req_addr) >= ADDR_W'(8192)) &&
     ($past(req_addr[ADDR_W-1:WS]) != $past(pfx_base[ADDR_W-1:WS])))
    |-> (rel_addr == $past(req_addr)) && (rel_len == $past(req_len)));

  // R9
  key_rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd_valid == $past(key_rd_en));
endmodule

bind prx_relocator prx_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_prx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .pfx_we       (pfx_we),
  .pfx_wdata    (pfx_wdata),
  .pfx_base     (pfx_base),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .req_len      (req_len),
  .rel_valid    (rel_valid),
  .rel_addr     (rel_addr),
  .rel_len      (rel_len),
  .key_rd_en    (key_rd_en),
  .key_rd_valid (key_rd_valid)
);

// File: tb/test_prx_relocator.sv
`timescale 1ns/1ps
module test_prx_relocator;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pfx_we = 1'b0;
  logic [AW-1:0] pfx_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_rd = 1'b0;
  logic          req_wr = 1'b0;
  logic          rel_valid;
  logic [AW-1:0] rel_addr;
  logic [LW-1:0] rel_len;
  logic          key_clr = 1'b0;
  logic          key_rd_en = 1'b0;
  logic [IW-1:0] key_rd_idx = '0;
  logic          key_rd_valid;
  logic [1:0]    key_rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prx_relocator i_prx_relocator (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic set_prefix(input logic [AW-1:0] v);
    @(negedge clk);
    pfx_we = 1'b1; pfx_wdata = v;
    @(negedge clk);
    pfx_we = 1'b0;
  endtask

  // One access; results checked one cycle later
  task automatic access(input string tag, input logic [AW-1:0] a, input logic [LW-1:0] l,
                        input logic rd, input logic wr,
                        input logic [AW-1:0] exp_a, input logic [LW-1:0] exp_l);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_rd = rd; req_wr = wr;
    @(posedge clk); #1;
    req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
    chk({tag, " valid"}, 64'(rel_valid), 64'd1);
    chk({tag, " addr"}, 64'(rel_addr), 64'(exp_a));
    chk({tag, " len"}, 64'(rel_len), 64'(exp_l));
  endtask

  task automatic key_check(input string tag, input int page, input logic [1:0] exp);
    @(negedge clk);
    key_rd_en = 1'b1; key_rd_idx = IW'(page);
    @(posedge clk); #1;
    key_rd_en = 1'b0;
    chk({tag, " key"}, 64'(key_rd_data), 64'(exp));
    chk({tag, " key_rd_valid R9"}, 64'(key_rd_valid), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 rel_valid after reset", 64'(rel_valid), 64'd0);
    key_check("R1 page0", 0, 2'b00);
    key_check("R1 page16", 16, 2'b00);
    access("R1 zero prefix", 32'h100, 16'd4, 1'b0, 1'b0, 32'h100, 16'd4);
  endtask

  task automatic t_low_zone;
    set_prefix(32'h0001_1FFF);
    access("R2 R3 masked prefix clipped", 32'h100, 16'h3000, 1'b1, 1'b0, 32'h0001_0100, 16'h1F00);
    access("R3 short", 32'h40, 16'd16, 1'b0, 1'b0, 32'h0001_0040, 16'd16);
    access("R3 last byte", 32'h1FFF, 16'd5, 1'b0, 1'b0, 32'h0001_1FFF, 16'd1);
  endtask

  task automatic t_win_zone;
    access("R4 clipped", 32'h0001_1F00, 16'h0400, 1'b0, 1'b1, 32'h1F00, 16'h0100);
    access("R4 start", 32'h0001_0010, 16'd8, 1'b0, 1'b0, 32'h10, 16'd8);
  endtask

  task automatic t_pass_zone;
    access("R5 addr 8192", 32'h2000, 16'h5000, 1'b0, 1'b0, 32'h2000, 16'h5000);
    access("R5 past window", 32'h0001_2000, 16'h4000, 1'b0, 1'b0, 32'h0001_2000, 16'h4000);
    access("R5 high", 32'h0002_0000, 16'h10, 1'b1, 1'b1, 32'h0002_0000, 16'h10);
  endtask

  task automatic t_keys;
    key_check("R6 ref page16", 16, 2'b01);
    key_check("R6 chg page1", 1, 2'b10);
    key_check("R6 both page32", 32, 2'b11);
    access("R6 sticky write", 32'h10, 16'd1, 1'b0, 1'b1, 32'h0001_0010, 16'd1);
    key_check("R6 sticky page16", 16, 2'b11);
  endtask

  task automatic t_mem_limit;
    set_prefix(32'h0);
    access("R7 at limit", 32'h0004_0000, 16'd1, 1'b1, 1'b0, 32'h0004_0000, 16'd1);
    key_check("R7 page64 set", 64, 2'b01);
    access("R7 above limit", 32'h0004_0001, 16'd1, 1'b0, 1'b1, 32'h0004_0001, 16'd1);
    key_check("R7 page64 unchanged", 64, 2'b01);
  endtask

  task automatic t_read_collide;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h3000; req_len = 16'd1; req_rd = 1'b1;
    key_rd_en = 1'b1; key_rd_idx = IW'(3);
    @(posedge clk); #1;
    req_valid = 1'b0; req_rd = 1'b0; key_rd_en = 1'b0;
    chk("R9 read during update old", 64'(key_rd_data), 64'd0);
    key_check("R9 read after update", 3, 2'b01);
  endtask

  task automatic t_clear;
    @(negedge clk);
    key_clr = 1'b1;
    req_valid = 1'b1; req_addr = 32'h5000; req_len = 16'd1; req_rd = 1'b1; req_wr = 1'b1;
    @(negedge clk);
    key_clr = 1'b0; req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
    key_check("R8 colliding page5", 5, 2'b00);
    key_check("R8 page64", 64, 2'b00);
    key_check("R8 page32", 32, 2'b00);
    key_check("R8 page16", 16, 2'b00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_zone();
    t_win_zone();
    t_pass_zone();
    t_keys();
    t_mem_limit();
    t_read_collide();
    t_clear();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule